// File: doc/BRIEF.md
# Interrupt Priority and Service Tracker

This block keeps the interrupt state of one processor across 256 vectors. A request bank holds one pending bit per vector and a service bank holds one in-service bit per vector, each organised as eight 32-bit groups. From these it offers the single best vector that may interrupt now, and it computes the processor priority. The processor priority is derived from a programmable task priority and from a stack of nested in-service vectors.

Requests arrive as single-cycle strobes carrying a vector number. The offered vector leaves on a valid/ready pair; taking it (valid and ready in the same cycle) is the accept. The vector then moves from the request bank to the service bank and is pushed on the nesting stack. An end-of-interrupt strobe retires the most important in-service vector. A task-priority write port raises or lowers the threshold. Back-pressure rules: while ready is low nothing is consumed and the offer is held. The offer may still change or withdraw if a higher request, an EOI or a task-priority write changes which vector qualifies. The value on `pend_vector` is meaningful only while `pend_valid` is high, and reads as zero otherwise.

Top module: `intr_prio_tracker`

## Requirements
- R1: A request strobe with vector v sets bit v of the request bank, with bit v%32 of group v/32. Vectors 0 to 31 are recorded but never offered.
- R2: The offer is the top set bit of the highest non-empty group among groups 7 down to 1. It is offered only when its class (vector bits [7:4]) is strictly greater than the class of the processor priority. Otherwise nothing is offered.
- R3: An accept clears the vector's request bit, sets its in-service bit and pushes it on the nesting stack. While `pend_ready` is low the offer stays unchanged if no other input changes.
- R4: The processor priority equals the task priority when the task priority's class is at least the class of the stack top. Otherwise it equals the stack top with its low 4 bits cleared. An empty stack reads as vector 0.
- R5: An EOI clears the highest set in-service bit in groups 7 to 1 and pops the stack. An EOI with nothing in service changes nothing.
- R6: A task-priority write keeps only the low 8 bits of the written word.
- R7: Stack entries above the permanent zero bottom have strictly increasing classes from bottom to top.
- R8: An accept when the stack already holds DEPTH vectors is refused. Request, service and stack state are left unchanged, and `ovf_err` sets and stays set until reset.
- R9: The offer and the processor priority reflect a request, accept, EOI or task-priority write from the next clock edge on, and not before.
- R10: In one cycle, an EOI is applied before an accept, and a request strobe is applied after the accept's clear. A vector accepted and requested in the same cycle therefore stays pending.
- R11: After reset, both banks and the stack are empty, the task priority is 0, nothing is offered, the processor priority is 0 and `ovf_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Vector being requested |
| pend_valid | output | 1 | A vector is offered |
| pend_vector | output | 8 | Offered vector, zero when none |
| pend_ready | input | 1 | Consumer takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 32 | Task-priority write data, low 8 bits kept |
| ppr | output | 8 | Current processor priority |
| ovf_err | output | 1 | Sticky nesting-stack overflow flag |

## Verification
On every cycle the assertions check several properties. The stack's classes must rise from bottom to top, and the count of in-service bits must match the stack depth. The processor priority must never fall below the task priority or the stack top's class, and the overflow flag must be sticky. They also check that a request bit lands, that an accept grows the stack, and that an EOI on an empty stack leaves it alone. Only the directed scenarios can show the concrete values: which vector is offered when the top group is blocked, and the exact priority after task writes. The same holds for the ordering of a same-cycle EOI with an accept, the one-cycle update latency, and the refused push at the depth limit.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  // Priority class of a vector: its top four bits.
  function automatic logic [3:0] vec_class(input logic [7:0] v);
    return v[7:4];
  endfunction
endpackage

// File: rtl/ipt_hi_scan.sv
// Finds the highest set bit among groups 1..NGROUPS-1; group 0 is never scanned.
module ipt_hi_scan #(
  parameter int GROUP_W = 32,
  parameter int NGROUPS = 8,
  localparam int NVEC   = GROUP_W * NGROUPS,
  localparam int VW     = $clog2(NVEC),
  localparam int GBW    = $clog2(GROUP_W)
) (
  input  logic [NVEC-1:0] bits,
  output logic            found,
  output logic [VW-1:0]   idx
);
  logic [NGROUPS-1:0]     grp_nz;
  logic [NGROUPS*GBW-1:0] msb_flat;
  logic                   low_group_unused;

  assign low_group_unused = ^bits[GROUP_W-1:0];

  function automatic logic [GBW-1:0] top_bit(input logic [GROUP_W-1:0] w);
    logic [GBW-1:0] r;
    r = '0;
    for (int b = 0; b < GROUP_W; b++)
      if (w[b]) r = GBW'(b);
    return r;
  endfunction

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    if (g == 0) begin : g_skip
      assign grp_nz[g]                = 1'b0;
      assign msb_flat[g*GBW +: GBW]   = '0;
    end else begin : g_scan
      assign grp_nz[g]                = |bits[g*GROUP_W +: GROUP_W];
      assign msb_flat[g*GBW +: GBW]   = top_bit(bits[g*GROUP_W +: GROUP_W]);
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = 1; g < NGROUPS; g++) begin
      if (grp_nz[g]) begin
        found = 1'b1;
        idx   = VW'(g * GROUP_W) + VW'(msb_flat[g*GBW +: GBW]);
      end
    end
  end
endmodule

// File: rtl/ipt_req_bank.sv
// Pending-request bank with clear-then-set update and best-candidate scan.
module ipt_req_bank #(
  parameter int GROUP_W = 32,
  parameter int NGROUPS = 8,
  localparam int NVEC   = GROUP_W * NGROUPS,
  localparam int VW     = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [VW-1:0] set_vec,
  input  logic          clr_valid,
  input  logic [VW-1:0] clr_vec,
  output logic          cand_found,
  output logic [VW-1:0] cand_vec
);
  logic [NVEC-1:0] irr, irr_next, clr_mask, set_mask;

  assign clr_mask = clr_valid ? (NVEC'(1) << clr_vec) : '0;
  assign set_mask = set_valid ? (NVEC'(1) << set_vec) : '0;
  assign irr_next = (irr & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) irr <= '0;
    else        irr <= irr_next;
  end

  ipt_hi_scan #(.GROUP_W(GROUP_W), .NGROUPS(NGROUPS)) u_scan (
    .bits (irr),
    .found(cand_found),
    .idx  (cand_vec)
  );

  // R1 and R10: a request always lands, even against a same-cycle clear.
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> irr[$past(set_vec)]);
endmodule

// File: rtl/ipt_svc_stack.sv
// In-service bank plus nesting stack; EOI pops first, then an accept pushes.
module ipt_svc_stack #(
  parameter int GROUP_W = 32,
  parameter int NGROUPS = 8,
  parameter int DEPTH   = 16,
  localparam int NVEC   = GROUP_W * NGROUPS,
  localparam int VW     = $clog2(NVEC),
  localparam int SPW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [VW-1:0] push_vec,
  input  logic          pop_req,
  output logic          push_ok,
  output logic [VW-1:0] top_vec,
  output logic          ovf_err
);
  logic [NVEC-1:0] isr, isr_next, isr_clr, isr_set;
  logic [VW-1:0]   stk [0:DEPTH];
  logic [SPW-1:0]  sp, sp_mid;
  logic            isr_found, pop_do, full_mid;
  logic [VW-1:0]   isr_hi;

  ipt_hi_scan #(.GROUP_W(GROUP_W), .NGROUPS(NGROUPS)) u_scan (
    .bits (isr),
    .found(isr_found),
    .idx  (isr_hi)
  );

  assign pop_do   = pop_req && isr_found;
  assign sp_mid   = pop_do ? sp - SPW'(1) : sp;
  assign full_mid = (sp_mid == SPW'(DEPTH));
  assign push_ok  = push && !full_mid;
  assign isr_clr  = pop_do  ? (NVEC'(1) << isr_hi)   : '0;
  assign isr_set  = push_ok ? (NVEC'(1) << push_vec) : '0;
  assign isr_next = (isr & ~isr_clr) | isr_set;
  assign top_vec  = stk[sp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr     <= '0;
      sp      <= '0;
      ovf_err <= 1'b0;
      for (int i = 0; i <= DEPTH; i++) stk[i] <= '0;
    end else begin
      isr <= isr_next;
      sp  <= push_ok ? sp_mid + SPW'(1) : sp_mid;
      if (push_ok) stk[sp_mid + SPW'(1)] <= push_vec;
      if (push && full_mid) ovf_err <= 1'b1;
    end
  end

  // R3: one in-service bit per stacked vector.
  a_r3_isr_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr) == 32'(sp));

  // R3: a push into free room grows the stack and marks the vector.
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_req && sp < SPW'(DEPTH)) |=> (sp == $past(sp) + SPW'(1)) && isr[$past(push_vec)]);

  // R5: EOI with nothing in service leaves the stack alone.
  a_r5_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push && sp == '0) |=> sp == '0);

  // R8: overflow flag is sticky.
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R7: classes rise strictly from the zero bottom to the top.
  for (genvar i = 1; i <= DEPTH; i++) begin : g_order
    a_r7_class_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (sp >= SPW'(i)) |-> (stk[i][VW-1:VW-4] > stk[i-1][VW-1:VW-4]));
  end
endmodule

// File: rtl/ipt_prio_calc.sv
// Processor priority and offer gate.
module ipt_prio_calc #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] tpr,
  input  logic [VW-1:0] top_vec,
  input  logic          cand_found,
  input  logic [VW-1:0] cand_vec,
  input  logic [VW-1:0] group_floor,
  output logic [VW-1:0] ppr,
  output logic          pend_valid,
  output logic [VW-1:0] pend_vector
);
  import ipt_pkg::*;

  logic tpr_wins;

  assign tpr_wins    = vec_class(tpr) >= vec_class(top_vec);
  assign ppr         = tpr_wins ? tpr : {top_vec[VW-1:4], 4'h0};
  assign pend_valid  = cand_found && (vec_class(cand_vec) > vec_class(ppr));
  assign pend_vector = pend_valid ? cand_vec : '0;

  // R4: processor priority never drops below the task priority or the top class.
  a_r4_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr >= tpr) && (vec_class(ppr) >= vec_class(top_vec)));

  // R2: the offer never comes from the unscanned lowest group.
  a_r2_pend_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> pend_vector >= group_floor);
endmodule

// File: rtl/intr_prio_tracker.sv
module intr_prio_tracker #(
  parameter int GROUP_W = 32,
  parameter int NGROUPS = 8,
  parameter int DEPTH   = 16,
  parameter int TPR_W   = 32,
  localparam int NVEC   = GROUP_W * NGROUPS,
  localparam int VW     = $clog2(NVEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VW-1:0]    req_vector,
  output logic             pend_valid,
  output logic [VW-1:0]    pend_vector,
  input  logic             pend_ready,
  input  logic             eoi,
  input  logic             tpr_we,
  input  logic [TPR_W-1:0] tpr_wdata,
  output logic [VW-1:0]    ppr,
  output logic             ovf_err
);
  logic [VW-1:0] tpr, top_vec, cand_vec;
  logic          cand_found, accept, push_ok, tpr_unused;

  assign tpr_unused = ^tpr_wdata[TPR_W-1:VW];
  assign accept     = pend_valid && pend_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      tpr <= '0;
    else if (tpr_we) tpr <= tpr_wdata[VW-1:0];
  end

  ipt_req_bank #(.GROUP_W(GROUP_W), .NGROUPS(NGROUPS)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (req_valid),
    .set_vec   (req_vector),
    .clr_valid (push_ok),
    .clr_vec   (pend_vector),
    .cand_found(cand_found),
    .cand_vec  (cand_vec)
  );

  ipt_svc_stack #(.GROUP_W(GROUP_W), .NGROUPS(NGROUPS), .DEPTH(DEPTH)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept),
    .push_vec(pend_vector),
    .pop_req (eoi),
    .push_ok (push_ok),
    .top_vec (top_vec),
    .ovf_err (ovf_err)
  );

  ipt_prio_calc #(.VW(VW)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .tpr        (tpr),
    .top_vec    (top_vec),
    .cand_found (cand_found),
    .cand_vec   (cand_vec),
    .group_floor(VW'(GROUP_W)),
    .ppr        (ppr),
    .pend_valid (pend_valid),
    .pend_vector(pend_vector)
  );
endmodule

// File: tb/tb_intr_prio_tracker.sv
module tb_intr_prio_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        pend_valid;
  logic [7:0]  pend_vector;
  logic        pend_ready = 1'b0;
  logic        eoi = 1'b0;
  logic        tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic [7:0]  ppr;
  logic        ovf_err;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  intr_prio_tracker #(.DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .pend_valid(pend_valid), .pend_vector(pend_vector), .pend_ready(pend_ready),
    .eoi(eoi), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr(ppr), .ovf_err(ovf_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic v, input logic [7:0] vec, input logic [7:0] p);
    chk({tag, " valid"}, 32'(pend_valid), 32'(v));
    chk({tag, " vector"}, 32'(pend_vector), 32'(vec));
    chk({tag, " ppr"}, 32'(ppr), 32'(p));
  endtask

  task automatic do_req(input logic [7:0] v);
    req_valid = 1'b1; req_vector = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_accept();
    pend_ready = 1'b1;
    @(negedge clk);
    pend_ready = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic do_tpr(input logic [31:0] d);
    tpr_we = 1'b1; tpr_wdata = d;
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R11 reset", 1'b0, 8'h00, 8'h00);
    chk("R11 reset ovf", 32'(ovf_err), 0);
  endtask

  task automatic t_request_and_latency();
    do_req(8'h05);
    chk("R1 low group never offered", 32'(pend_valid), 0);
    req_valid = 1'b1; req_vector = 8'h40;
    #1;
    chk("R9 no change before edge", 32'(pend_valid), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk_out("R2 R9 offer after edge", 1'b1, 8'h40, 8'h00);
  endtask

  task automatic t_accept_and_block();
    do_accept();
    chk_out("R3 R4 after accept", 1'b0, 8'h00, 8'h40);
    do_req(8'h48);
    do_req(8'h30);
    chk("R2 same class blocked", 32'(pend_valid), 0);
  endtask

  task automatic t_task_priority();
    do_tpr(32'hABCD_0057);
    chk("R6 R4 tpr low byte", 32'(ppr), 32'h57);
    do_tpr(32'h0000_0030);
    chk("R4 top class wins", 32'(ppr), 32'h40);
    do_tpr(32'h0000_004F);
    chk("R4 equal class tpr wins", 32'(ppr), 32'h4F);
    do_tpr(32'h0);
    chk("R4 tpr zero", 32'(ppr), 32'h40);
  endtask

  task automatic t_eoi();
    do_eoi();
    chk_out("R5 eoi pops", 1'b1, 8'h48, 8'h00);
    do_accept();
    chk("R3 nested accept", 32'(ppr), 32'h40);
    do_eoi();
    chk_out("R2 next group offered", 1'b1, 8'h30, 8'h00);
    do_accept();
    do_eoi();
    chk_out("R1 only low group left", 1'b0, 8'h00, 8'h00);
    do_eoi();
    chk_out("R5 empty eoi no effect", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_backpressure();
    do_req(8'h60);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_out("R3 held without ready", 1'b1, 8'h60, 8'h00);
    end
  endtask

  task automatic t_same_cycle();
    do_accept();
    do_req(8'h70);
    chk("R2 higher class offered", 32'(pend_vector), 32'h70);
    eoi = 1'b1; pend_ready = 1'b1;
    @(negedge clk);
    eoi = 1'b0; pend_ready = 1'b0;
    chk_out("R10 eoi then accept", 1'b0, 8'h00, 8'h70);
    do_eoi();
    chk("R10 single entry left", 32'(ppr), 0);
    do_req(8'h80);
    pend_ready = 1'b1; req_valid = 1'b1; req_vector = 8'h80;
    @(negedge clk);
    pend_ready = 1'b0; req_valid = 1'b0;
    chk_out("R10 re-request while accepted", 1'b0, 8'h00, 8'h80);
    do_eoi();
    chk_out("R10 re-request survives", 1'b1, 8'h80, 8'h00);
    do_accept();
    do_eoi();
    chk("R5 cleaned", 32'(ppr), 0);
  endtask

  task automatic t_overflow();
    for (int i = 3; i <= 6; i++) begin
      do_req(8'((i << 4) | 5));
      do_accept();
    end
    chk("R3 four nested", 32'(ppr), 32'h60);
    chk("R8 no overflow yet", 32'(ovf_err), 0);
    do_req(8'h75);
    do_accept();
    chk_out("R8 push refused", 1'b1, 8'h75, 8'h60);
    chk("R8 flag set", 32'(ovf_err), 1);
    do_eoi();
    chk_out("R8 pop after refusal", 1'b1, 8'h75, 8'h50);
    chk("R8 flag sticky", 32'(ovf_err), 1);
    do_accept();
    chk("R7 accepted after room", 32'(ppr), 32'h70);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_request_and_latency();
    t_accept_and_block();
    t_task_priority();
    t_eoi();
    t_backpressure();
    t_same_cycle();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule